// File: doc/BRIEF.md
# Three-Bit Operation-Select Register

This block holds three bits in D flip-flops and rewrites them on every rising clock edge according to a three-bit operation code. Five operations are defined. Hold keeps the value. Invert flips every bit. Shift-right moves the bits one place toward bit 0 and fills bit 2 with zero. Preset loads the fixed pattern 011. Clear zeroes the register. Any code that is not defined behaves as hold.

The operation code is decoded once into a small set of control lines. Each bit then has its own slice, which selects that bit's next value from its own output, its upper neighbour, the preset constant or zero. A synchronous active-high reset has priority over every code and forces 000.

Top module: `opsel_reg3`

## Requirements
- R1: While `rst` is high at a rising edge, `q_o` becomes 000 after that edge, whatever `op_i` holds.
- R2: Code 000 (hold) leaves `q_o` unchanged across the edge.
- R3: Code 001 (invert) replaces every bit of `q_o` with its complement.
- R4: Code 010 (shift right) sets bit 2 to 0, bit 1 to the old bit 2 and bit 0 to the old bit 1. The old bit 0 is lost.
- R5: Code 011 (preset) loads binary 011 (bit 2 = 0, bits 1 and 0 = 1), whatever the previous value.
- R6: Code 100 (clear) loads 000, whatever the previous value.
- R7: Codes 101, 110 and 111 behave as hold and leave `q_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All updates happen on its rising edge. |
| rst | input | 1 | Synchronous reset, active high. Forces 000. |
| op_i | input | 3 | Operation code: 000 hold, 001 invert, 010 shift right, 011 preset, 100 clear. Other codes hold. |
| q_o | output | 3 | Register contents. |

## Verification
The preset value 011 is chosen as the starting point for invert because the result, 100, differs from the start in every bit position. Repeated shifts walk a single 1 from bit 2 down to bit 0 and then out of the register. This shows that bit 2 is filled with zero and that the old bit 0 is dropped. A shift from 111 gives 011, which tells the zero fill apart from a rotate. The undefined codes are applied to a register holding a nonzero value, so an accidental clear or invert would be visible. Reset is applied while the invert and preset codes are on the input, to confirm that reset has priority.

// File: rtl/opsel_reg3_pkg.sv
package opsel_reg3_pkg;

    localparam int unsigned OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_HOLD   = 3'b000,
        OP_INV    = 3'b001,
        OP_SHR    = 3'b010,
        OP_PRESET = 3'b011,
        OP_CLR    = 3'b100
    } op_e;

    // One-hot (or all-zero for hold) control lines shared by every slice.
    typedef struct packed {
        logic inv;
        logic shr;
        logic preset;
        logic clr;
    } ctl_t;

    function automatic ctl_t decode_op(logic [OP_W-1:0] code);
        ctl_t c;
        c = '0;
        case (code)
            OP_INV:    c.inv    = 1'b1;
            OP_SHR:    c.shr    = 1'b1;
            OP_PRESET: c.preset = 1'b1;
            OP_CLR:    c.clr    = 1'b1;
            default:   c        = '0;  // hold, including codes 101..111 (R7)
        endcase
        return c;
    endfunction

endpackage

// File: rtl/opsel_reg3_dec.sv
module opsel_reg3_dec
    import opsel_reg3_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output ctl_t            ctl_o
);
    always_comb begin
        ctl_o = decode_op(op_i);
    end
endmodule

// File: rtl/opsel_reg3_slice.sv
module opsel_reg3_slice
    import opsel_reg3_pkg::*;
#(
    parameter logic PRESET_BIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl_i,
    input  logic upper_i,   // neighbour toward the MSB; 0 for the top bit
    output logic q_o
);
    logic d;

    always_comb begin
        if (ctl_i.clr)         d = 1'b0;
        else if (ctl_i.preset) d = PRESET_BIT;
        else if (ctl_i.shr)    d = upper_i;
        else if (ctl_i.inv)    d = ~q_o;
        else                   d = q_o;
    end

    always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= d;
    end
endmodule

// File: rtl/opsel_reg3.sv
module opsel_reg3
    import opsel_reg3_pkg::*;
#(
    parameter int unsigned    WIDTH      = 3,
    parameter logic [WIDTH-1:0] PRESET_VAL = 3'b011
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  op_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int unsigned MSB = WIDTH - 1;

    ctl_t ctl;

    opsel_reg3_dec u_dec (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic upper;
        if (i == MSB) begin : g_top
            assign upper = 1'b0;          // zero fill on shift (R4)
        end else begin : g_inner
            assign upper = q_o[i+1];
        end

        opsel_reg3_slice #(
            .PRESET_BIT (PRESET_VAL[i])
        ) u_slice (
            .clk     (clk),
            .rst     (rst),
            .ctl_i   (ctl),
            .upper_i (upper),
            .q_o     (q_o[i])
        );
    end
endmodule

// File: rtl/opsel_reg3_chk.sv
module opsel_reg3_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] op_i,
    input logic [2:0] q_o
);
    // R2
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b000) |=> (q_o == $past(q_o)));

    // R3
    a_r3_invert: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b001) |=> (q_o == ~$past(q_o)));

    // R4
    a_r4_shift_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b010) |=> (q_o == {1'b0, $past(q_o[2:1])}));

    // R5
    a_r5_preset: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b011) |=> (q_o == 3'b011));

    // R6
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b100) |=> (q_o == 3'b000));

    // R7
    a_r7_spare_hold: assert property (@(posedge clk) disable iff (rst)
        (op_i[2] && (op_i[1:0] != 2'b00)) |=> $stable(q_o));
endmodule

bind opsel_reg3 opsel_reg3_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .op_i (op_i),
    .q_o  (q_o)
);

// File: tb/opsel_reg3_tb_top.sv
module opsel_reg3_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op  = 3'b000;
    logic [2:0] q;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;  // 4 ns period

    opsel_reg3 dut_i (
        .clk  (clk),
        .rst  (rst),
        .op_i (op),
        .q_o  (q)
    );

    // {op, expected q after the edge}, walked in order from 000
    localparam int NV = 17;
    localparam logic [5:0] VEC [NV] = '{
        {3'b011, 3'b011},  // preset
        {3'b001, 3'b100},  // invert
        {3'b010, 3'b010},  // shift
        {3'b010, 3'b001},
        {3'b010, 3'b000},  // bit 0 lost
        {3'b001, 3'b111},
        {3'b010, 3'b011},  // zero fill, not rotate
        {3'b000, 3'b011},  // hold
        {3'b101, 3'b011},  // spare codes
        {3'b110, 3'b011},
        {3'b111, 3'b011},
        {3'b100, 3'b000},  // clear
        {3'b000, 3'b000},
        {3'b011, 3'b011},
        {3'b011, 3'b011},
        {3'b001, 3'b100},
        {3'b100, 3'b000}
    };

    function automatic string req_of(logic [2:0] code);
        case (code)
            3'b000:  return "R2";
            3'b001:  return "R3";
            3'b010:  return "R4";
            3'b011:  return "R5";
            3'b100:  return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, logic [2:0] exp);
        n_run++;
        if (q !== exp) begin
            n_fail++;
            $display("FAIL %s: q=%b expected %b", req, q, exp);
        end
    endtask

    task automatic step(logic [2:0] code);
        @(negedge clk);
        op = code;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run hung");
        finish_run();
    end

    initial begin
        // R1: reset with invert on the input still gives 000
        op = 3'b001;
        repeat (3) @(posedge clk);
        #1;
        check("R1", 3'b000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][5:3]);
            check(req_of(VEC[i][5:3]), VEC[i][2:0]);
        end

        // R3: 000 -> 111 -> 000
        step(3'b001); check("R3", 3'b111);
        step(3'b001); check("R3", 3'b000);
        // R4: shifting zero stays zero
        step(3'b010); check("R4", 3'b000);
        // R7: spare codes on 111 keep it
        step(3'b001); check("R3", 3'b111);
        step(3'b111); check("R7", 3'b111);
        step(3'b101); check("R7", 3'b111);

        // R1: synchronous reset from 111 while preset is requested
        @(negedge clk);
        op  = 3'b011;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", 3'b000);
        @(negedge clk);
        rst = 1'b0;
        op  = 3'b000;
        @(posedge clk);
        #1;
        check("R2", 3'b000);

        finish_run();
    end
endmodule